// File: doc/BRIEF.md
# Dual Compare-Match Timer

This block holds two independent 16-bit up-counters behind a small halfword-addressed register window. Each counter advances once per prescaled tick of the peripheral clock, compares itself with its own match register, and on equality returns to zero on that tick. Each channel picks one of four clock divisions and can raise a single-cycle interrupt pulse whenever its count wraps on a match.

Host software programs the division and interrupt enable in a channel's control word, sets the match and optionally the starting count, then sets that channel's bit in the shared start word. Clearing the bit freezes the counter in place. Reads are combinational from the current state, so the value of the register at `busAddr` is always present on `busRdata`.

Top module: `dual_match_timer`

## Requirements
- R1: The halfword index is `busAddr[3:1]` (bit 0 is ignored): index 0 is the start word, indices 1, 2 and 3 are the control, count and match of channel 0, indices 4, 5 and 6 the same three for channel 1. Index 7 reads as 0, and writes to it change no register.
- R2: After a synchronous reset both counts read 0, both control words read 0x0080, the start word reads 0, both match registers read 0xFFFF and both interrupt outputs are low.
- R3: Control bits [1:0] pick the divide ratio 8 << (2 × value), so 8, 32, 128 or 512 clock cycles per tick. Bit 6 is the interrupt enable, bit 7 always reads 1, and every other bit reads 0 whatever was written.
- R4: Bit n of the start word runs channel n. A read returns the two run bits in bits [1:0], and bits above them read 0.
- R5: A running channel increments once per tick; a stopped channel holds its count. The prescaler sits at its first phase while stopped, so the first increment after a start lands exactly on the divide-ratio-th clock edge after the edge that wrote the start word.
- R6: A tick that finds the count equal to the match value loads 0 instead of incrementing, giving a period of match + 1 ticks.
- R7: Such a wrap drives that channel's interrupt output high for exactly the following clock cycle when its enable bit was set at that edge; with the enable clear the output stays low.
- R8: A host write to a count register takes effect at the next edge even when a tick falls on the same edge, and a wrap that coincides with such a write raises no interrupt.
- R9: A write to one channel's control, count or match register leaves the other channel's registers and its interrupt timing unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous reset, active high |
| busSel | input | 1 | Access strobe for the register window |
| busWrite | input | 1 | Write when high together with busSel |
| busAddr | input | 4 | Byte address of the halfword register |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data of the register at busAddr |
| irqOut | output | 2 | One-cycle interrupt pulse per channel |

## Verification
The bound checker watches on every cycle that an interrupt pulse never lasts two cycles, only appears with the enable set, and always coincides with a zero count, that a stopped channel's count never moves, that an unwritten count only ever holds, steps by one or clears, and that control reads carry the fixed and zero bits. The exact tick spacing for each divide ratio, the start-to-first-increment latency, the match period, write-versus-tick priority and the channel independence are only visible through the bench's cycle-accurate reference model and its scenarios, which compare read data and both interrupt outputs every cycle and count pulses over fixed windows.

// File: rtl/dmt_pkg.sv
package dmt_pkg;

  // control word layout (bit positions decoded by the host)
  localparam int DIV_SEL_W    = 2;
  localparam int IRQ_EN_BIT   = 6;
  localparam int FIXED_BIT    = 7;
  localparam int REGS_PER_CH  = 3;

  // prescaler shape: divide = 2^(DIV_BASE_LOG2 + DIV_STEP_LOG2 * select)
  localparam int DIV_BASE_LOG2 = 3;
  localparam int DIV_STEP_LOG2 = 2;
  localparam int DIV_SEL_MAX   = (1 << DIV_SEL_W) - 1;
  localparam int PRE_W         = DIV_BASE_LOG2 + DIV_STEP_LOG2 * DIV_SEL_MAX;

  // per-channel strobes and settings handed from control to datapath
  typedef struct packed {
    logic                 run;
    logic                 irqEn;
    logic [DIV_SEL_W-1:0] divSel;
    logic                 wrCount;
    logic                 wrMatch;
  } chStrobe_t;

endpackage

// File: rtl/dmt_ctrl.sv
module dmt_ctrl
  import dmt_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           busSel,
  input  logic                           busWrite,
  input  logic [ADDR_W-1:0]              busAddr,
  input  logic [DATA_W-1:0]              busWdata,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  cntVal,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  matchVal,
  output chStrobe_t [NUM_CH-1:0]         strobes,
  output logic [DATA_W-1:0]              busRdata
);

  localparam int IDX_W = ADDR_W - 1;
  localparam logic [IDX_W-1:0] START_IDX = '0;

  logic [IDX_W-1:0]             regIdx;
  logic                         wrEn;
  logic [NUM_CH-1:0]            runBits;
  logic [NUM_CH-1:0][DATA_W-1:0] ctlWord;
  logic                         unusedAddrData;

  assign regIdx = busAddr[ADDR_W-1:1];
  assign wrEn   = busSel & busWrite;
  assign unusedAddrData = ^{busAddr[0], busWdata};

  // shared start word: one run bit per channel
  always_ff @(posedge clk) begin
    if (rst) begin
      runBits <= '0;
    end else if (wrEn && regIdx == START_IDX) begin
      runBits <= busWdata[NUM_CH-1:0];
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chCtl
    localparam logic [IDX_W-1:0] CTL_IDX   = IDX_W'(1 + REGS_PER_CH * ch);
    localparam logic [IDX_W-1:0] CNT_IDX   = IDX_W'(2 + REGS_PER_CH * ch);
    localparam logic [IDX_W-1:0] MATCH_IDX = IDX_W'(3 + REGS_PER_CH * ch);

    logic [DIV_SEL_W-1:0] divSel;
    logic                 irqEn;

    always_ff @(posedge clk) begin
      if (rst) begin
        divSel <= '0;
        irqEn  <= 1'b0;
      end else if (wrEn && regIdx == CTL_IDX) begin
        divSel <= busWdata[DIV_SEL_W-1:0];
        irqEn  <= busWdata[IRQ_EN_BIT];
      end
    end

    always_comb begin
      ctlWord[ch]                   = '0;
      ctlWord[ch][DIV_SEL_W-1:0]    = divSel;
      ctlWord[ch][IRQ_EN_BIT]       = irqEn;
      ctlWord[ch][FIXED_BIT]        = 1'b1;
    end

    assign strobes[ch].run     = runBits[ch];
    assign strobes[ch].irqEn   = irqEn;
    assign strobes[ch].divSel  = divSel;
    assign strobes[ch].wrCount = wrEn && (regIdx == CNT_IDX);
    assign strobes[ch].wrMatch = wrEn && (regIdx == MATCH_IDX);
  end

  // read mux, combinational from current state
  always_comb begin
    busRdata = '0;
    if (regIdx == START_IDX) begin
      busRdata[NUM_CH-1:0] = runBits;
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (regIdx == IDX_W'(1 + REGS_PER_CH * c)) busRdata = ctlWord[c];
      if (regIdx == IDX_W'(2 + REGS_PER_CH * c)) busRdata = cntVal[c];
      if (regIdx == IDX_W'(3 + REGS_PER_CH * c)) busRdata = matchVal[c];
    end
  end

endmodule

// File: rtl/dmt_datapath.sv
module dmt_datapath
  import dmt_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  chStrobe_t [NUM_CH-1:0]        strobes,
  input  logic [CNT_W-1:0]              wrData,
  output logic [NUM_CH-1:0][CNT_W-1:0]  cntVal,
  output logic [NUM_CH-1:0][CNT_W-1:0]  matchVal,
  output logic [NUM_CH-1:0]             irqOut
);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chPath
    logic [PRE_W-1:0] preCnt;
    logic [PRE_W-1:0] divLast;
    logic             tick;
    logic             hit;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] match;
    logic             irqQ;

    // last prescaler phase for the selected ratio
    always_comb begin
      divLast = '0;
      for (int s = 0; s <= DIV_SEL_MAX; s++) begin
        if (strobes[ch].divSel == DIV_SEL_W'(s)) begin
          divLast = PRE_W'((1 << (DIV_BASE_LOG2 + DIV_STEP_LOG2 * s)) - 1);
        end
      end
    end

    // >= so a ratio lowered mid-run still ends the phase at once
    assign tick = strobes[ch].run && (preCnt >= divLast);
    assign hit  = tick && (count == match);

    always_ff @(posedge clk) begin
      if (rst || !strobes[ch].run) begin
        preCnt <= '0;
      end else if (tick) begin
        preCnt <= '0;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        count <= '0;
      end else if (strobes[ch].wrCount) begin
        count <= wrData;
      end else if (hit) begin
        count <= '0;
      end else if (tick) begin
        count <= count + 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        match <= '1;
      end else if (strobes[ch].wrMatch) begin
        match <= wrData;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        irqQ <= 1'b0;
      end else begin
        irqQ <= hit && strobes[ch].irqEn && !strobes[ch].wrCount;
      end
    end

    assign cntVal[ch]   = count;
    assign matchVal[ch] = match;
    assign irqOut[ch]   = irqQ;
  end

endmodule

// File: rtl/dual_match_timer.sv
module dual_match_timer
  import dmt_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [NUM_CH-1:0] irqOut
);

  chStrobe_t [NUM_CH-1:0]        strobes;
  logic [NUM_CH-1:0][DATA_W-1:0] cntVal;
  logic [NUM_CH-1:0][DATA_W-1:0] matchVal;

  dmt_ctrl #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .cntVal   (cntVal),
    .matchVal (matchVal),
    .strobes  (strobes),
    .busRdata (busRdata)
  );

  dmt_datapath #(
    .NUM_CH (NUM_CH),
    .CNT_W  (DATA_W)
  ) u_datapath (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .wrData   (busWdata),
    .cntVal   (cntVal),
    .matchVal (matchVal),
    .irqOut   (irqOut)
  );

endmodule

// File: rtl/dmt_checker.sv
module dmt_checker
  import dmt_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input logic                          clk,
  input logic                          rst,
  input logic [ADDR_W-1:0]             busAddr,
  input logic [DATA_W-1:0]             busRdata,
  input logic [NUM_CH-1:0]             irqOut,
  input chStrobe_t [NUM_CH-1:0]        strobes,
  input logic [NUM_CH-1:0][DATA_W-1:0] cntVal
);

  localparam int IDX_W = ADDR_W - 1;

  logic [IDX_W-1:0] chkIdx;
  assign chkIdx = busAddr[ADDR_W-1:1];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R7: a pulse never lasts more than one cycle
    p_irq_single_r7: assert property (@(posedge clk) disable iff (rst)
      irqOut[c] |=> !irqOut[c]);

    // R7: a pulse only follows an edge with the enable set
    p_irq_enabled_r7: assert property (@(posedge clk) disable iff (rst)
      irqOut[c] |-> $past(strobes[c].irqEn));

    // R6: the pulse accompanies the wrap to zero
    p_wrap_zero_r6: assert property (@(posedge clk) disable iff (rst)
      irqOut[c] |-> (cntVal[c] == '0));

    // R5: a stopped, unwritten counter holds
    p_hold_stopped_r5: assert property (@(posedge clk) disable iff (rst)
      (!strobes[c].run && !strobes[c].wrCount) |=> (cntVal[c] == $past(cntVal[c])));

    // R5: without a host write the count holds, steps by one, or clears
    p_step_one_r5: assert property (@(posedge clk) disable iff (rst)
      !strobes[c].wrCount |=> ((cntVal[c] == $past(cntVal[c])) ||
                               (cntVal[c] == $past(cntVal[c]) + 1'b1) ||
                               (cntVal[c] == '0)));

    // R3: control read carries the fixed one and zero filler bits
    p_ctl_fixed_r3: assert property (@(posedge clk) disable iff (rst)
      (chkIdx == IDX_W'(1 + REGS_PER_CH * c)) |->
        (busRdata[FIXED_BIT] && busRdata[DATA_W-1:FIXED_BIT+1] == '0 &&
         busRdata[IRQ_EN_BIT-1:DIV_SEL_W] == '0));
  end

  // R4: start word read shows nothing above the run bits
  p_start_upper_r4: assert property (@(posedge clk) disable iff (rst)
    (chkIdx == '0) |-> (busRdata[DATA_W-1:NUM_CH] == '0));

endmodule

bind dual_match_timer dmt_checker #(
  .NUM_CH (NUM_CH),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_dmtChk (
  .clk      (clk),
  .rst      (rst),
  .busAddr  (busAddr),
  .busRdata (busRdata),
  .irqOut   (irqOut),
  .strobes  (strobes),
  .cntVal   (cntVal)
);

// File: tb/test_dual_match_timer.sv
module test_dual_match_timer;

  localparam int CLK_P  = 10;
  localparam int WD_CYC = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  wire  [15:0] busRdata;
  wire  [1:0]  irqOut;

  int total = 0;
  int bad   = 0;
  bit cmpEn = 1'b0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  dual_match_timer i_dual_match_timer (
    .clk      (clk),
    .rst      (rst),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .irqOut   (irqOut)
  );

  // ---------------- behavioural reference model ----------------
  int mCnt[2], mMatch[2], mSel[2], mIe[2], mRun[2], mPhase[2];
  bit mIrq[2];

  always @(posedge clk) begin
    int idx, div;
    bit wr, wrCtl, wrCnt, wrM, tk;
    if (rst) begin
      for (int c = 0; c < 2; c++) begin
        mCnt[c] = 0; mMatch[c] = 65535; mSel[c] = 0; mIe[c] = 0;
        mRun[c] = 0; mPhase[c] = 0; mIrq[c] = 0;
      end
    end else begin
      idx = int'(busAddr[3:1]);
      wr  = busSel && busWrite;
      for (int c = 0; c < 2; c++) begin
        wrCtl = wr && (idx == 1 + 3*c);
        wrCnt = wr && (idx == 2 + 3*c);
        wrM   = wr && (idx == 3 + 3*c);
        div   = 8 << (2*mSel[c]);
        tk    = 1'b0;
        if (mRun[c] != 0) begin
          mPhase[c] = mPhase[c] + 1;
          if (mPhase[c] >= div) begin
            tk = 1'b1;
            mPhase[c] = 0;
          end
        end else begin
          mPhase[c] = 0;
        end
        mIrq[c] = tk && (mCnt[c] == mMatch[c]) && (mIe[c] != 0) && !wrCnt;
        if (wrCnt) mCnt[c] = int'(busWdata);
        else if (tk) mCnt[c] = (mCnt[c] == mMatch[c]) ? 0 : (mCnt[c] + 1) % 65536;
        if (wrM) mMatch[c] = int'(busWdata);
        if (wrCtl) begin
          mSel[c] = int'(busWdata[1:0]);
          mIe[c]  = int'(busWdata[6]);
        end
      end
      if (wr && idx == 0) begin
        mRun[0] = int'(busWdata[0]);
        mRun[1] = int'(busWdata[1]);
      end
    end
  end

  function automatic int modelRead(input logic [3:0] a);
    int idx = int'(a[3:1]);
    if (idx == 0) return mRun[0] + 2*mRun[1];
    for (int c = 0; c < 2; c++) begin
      if (idx == 1 + 3*c) return 128 + 64*mIe[c] + mSel[c];
      if (idx == 2 + 3*c) return mCnt[c];
      if (idx == 3 + 3*c) return mMatch[c];
    end
    return 0;
  endfunction

  // ---------------- checking helpers ----------------
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always begin
    @(negedge clk);
    #(CLK_P/4);
    if (cmpEn && !done) begin
      chk(int'(busRdata) == modelRead(busAddr), "R1 per-cycle readback",
          int'(busRdata), modelRead(busAddr));
      for (int c = 0; c < 2; c++) begin
        chk(irqOut[c] == mIrq[c], "R7 per-cycle irq", int'(irqOut[c]), int'(mIrq[c]));
      end
    end
  end

  task automatic busWr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic readReg(input logic [3:0] a, output int v);
    @(negedge clk);
    busAddr = a;
    #1;
    v = int'(busRdata);
  endtask

  task automatic expectReg(input logic [3:0] a, input int e, input string tag);
    int v;
    readReg(a, v);
    chk(v == e, tag, v, e);
  endtask

  task automatic countPulses(input int n, output int p0, output int p1);
    p0 = 0; p1 = 0;
    repeat (n) begin
      @(negedge clk);
      #1;
      p0 += int'(irqOut[0]);
      p1 += int'(irqOut[1]);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  // watchdog
  initial begin
    #(CLK_P * WD_CYC);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      summary();
      $finish;
    end
  end

  // ---------------- scenarios ----------------
  initial begin
    int p0, p1, v, vMax, vA, vB;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cmpEn = 1'b1;

    // R2: reset values
    expectReg(4'h0, 0,      "R2 start word");
    expectReg(4'h2, 'h80,   "R2 ctl0");
    expectReg(4'h4, 0,      "R2 count0");
    expectReg(4'h6, 'hFFFF, "R2 match0");
    expectReg(4'h8, 'h80,   "R2 ctl1");
    expectReg(4'hC, 'hFFFF, "R2 match1");
    chk(irqOut == 2'b00, "R2 irq low", int'(irqOut), 0);
    expectReg(4'hE, 0,      "R1 index 7 reads 0");

    // R3: writable bits only
    busWr(4'h2, 16'hFFFF);
    expectReg(4'h2, 'hC3, "R3 ctl0 mask");
    busWr(4'h2, 16'h0040);
    expectReg(4'h2, 'hC0, "R3 ctl0 div8 ie");

    // R5: start latency for div 8
    busWr(4'h6, 16'd5);
    busWr(4'h0, 16'h0001);
    expectReg(4'h0, 1, "R4 run bit readback");
    repeat (5) @(negedge clk);
    expectReg(4'h4, 0, "R5 before 8th edge");
    expectReg(4'h4, 1, "R5 at 8th edge");

    // R7: div 8, match 5 -> pulse every 48 cycles
    countPulses(480, p0, p1);
    chk(p0 == 10, "R7 ch0 pulse count", p0, 10);
    chk(p1 == 0,  "R9 ch1 idle no pulse", p1, 0);

    // R6: count never passes match, and reaches it
    vMax = 0;
    busAddr = 4'h4;
    repeat (100) begin
      @(negedge clk); #1;
      if (int'(busRdata) > vMax) vMax = int'(busRdata);
    end
    chk(vMax == 5, "R6 max count equals match", vMax, 5);

    // R8: hold a count write across a tick edge
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = 4'h4; busWdata = 16'd5;
    repeat (9) @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
    #1;
    chk(int'(busRdata) == 5, "R8 write wins over tick", int'(busRdata), 5);

    // R9 / R7: ch1 div 32 without enable, both running
    busWr(4'h8, 16'h0001);
    busWr(4'hC, 16'd3);
    busWr(4'h0, 16'h0003);
    expectReg(4'h8, 'h81, "R9 ctl1 written");
    expectReg(4'h2, 'hC0, "R9 ctl0 unchanged");
    countPulses(960, p0, p1);
    chk(p1 == 0,  "R7 disabled ch1 silent", p1, 0);
    chk(p0 == 20, "R9 ch0 timing unchanged", p0, 20);

    // R4: stop via start word, upper bits ignored
    busWr(4'h0, 16'hFFFC);
    expectReg(4'h0, 0, "R4 both stopped");
    readReg(4'hA, vA);
    repeat (100) @(negedge clk);
    readReg(4'hA, vB);
    chk(vA == vB, "R5 stopped count holds", vB, vA);

    // R3: div 128 (match 0) and div 512 (match 1)
    busWr(4'h2, 16'h0042);
    busWr(4'h6, 16'd0);
    busWr(4'h4, 16'd0);
    busWr(4'h8, 16'h0043);
    busWr(4'hC, 16'd1);
    busWr(4'hA, 16'd0);
    busWr(4'h0, 16'h0003);
    countPulses(3072, p0, p1);
    chk(p0 == 24, "R3 div128 pulses", p0, 24);
    chk(p1 == 3,  "R3 div512 pulses", p1, 3);

    // R1: index 7 writes change nothing
    busWr(4'hE, 16'hFFFF);
    expectReg(4'hE, 0,     "R1 index 7 after write");
    expectReg(4'h2, 'hC2,  "R1 ctl0 intact");
    expectReg(4'h6, 0,     "R1 match0 intact");

    // R2: reset while running
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    expectReg(4'h0, 0,      "R2 start after reset");
    expectReg(4'h4, 0,      "R2 count0 after reset");
    expectReg(4'h8, 'h80,   "R2 ctl1 after reset");
    expectReg(4'h6, 'hFFFF, "R2 match0 after reset");
    chk(irqOut == 2'b00, "R2 irq after reset", int'(irqOut), 0);

    repeat (4) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule